// File: doc/BRIEF.md
# Programmable Horizontal Sync Generator

The block follows an 8-bit digital video byte stream with embedded timing codes. The stream is clocked once per pixel clock. The block looks for the code that marks the end of active video: the bytes FF, 00, 00 followed by a status byte whose H flag is set. When it finds one, it restarts a line position counter.

The counter drives a horizontal sync output. The sync asserts at a programmable begin position and drops at a programmable end position, and its polarity can be chosen. A standard-select input sets the line length, so the counter wraps on its own when a code is missing.

Software moves the pulse with two 11-bit offsets counted from position 0:
- To move the pulse later by N cycles, add N to both offsets.
- To move it earlier by N cycles, add (line total − N) to both offsets. The comparison then works modulo the line.

All three settings are loaded together through one write strobe.

Top module: `hsync_gen`

## Requirements
- R1: After reset `hs_out` is low, the begin offset is 2, the end offset is 0 and the polarity is 0. With idle video the output rises after the third clock edge following reset release.
- R2: The counter becomes 0 on the clock edge that samples the fourth byte of a code. A code is FF, 00, 00 on consecutive clocks, then a status byte with bit 4 set to 1.
- R3: Code matching is strict. A byte other than the expected one abandons the match. A FF at any point restarts the match at its first byte. A status byte with bit 4 equal to 0 is not a match.
- R4: Without a code, the counter wraps from (line total − 1) to 0. `std_sel` sets the line total: 0 gives 1716, 1 gives 1560, 2 gives 1728 and 3 gives 1716.
- R5: The internal sync becomes active on the edge after the counter equals the begin offset. It becomes inactive on the edge after the counter equals the end offset. If the two offsets are equal, the sync stays active.
- R6: With `cfg_pol` = 0 the output is high while sync is active. With `cfg_pol` = 1 it is low while sync is active.
- R7: Offsets of the form (line total − N) place a pulse that spans the wrap point of the line correctly.
- R8: `cfg_we` loads the begin offset, end offset and polarity together on a clock edge. The new values govern the comparisons from the following edge on.
- R9: A code that arrives in the middle of a line re-aligns the counter at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| vid_byte | input | 8 | Video byte stream |
| std_sel | input | 2 | Line length select |
| cfg_we | input | 1 | Configuration load strobe |
| cfg_beg | input | 11 | Begin offset to load |
| cfg_end | input | 11 | End offset to load |
| cfg_pol | input | 1 | Polarity to load (1 = active low) |
| hs_out | output | 1 | Horizontal sync output |

## Verification
The bench builds the block with its default parameters: 11-bit offsets and line totals of 1716, 1560 and 1728. For every standard select code it applies four offset pairs (reset default, shifted forward, shifted backward across the wrap, and a narrow mid-line pulse) with both polarities. It then compares the output on every cycle of a whole line that runs with no code, so the free-running wrap is covered as well. Short directed streams cover broken and restarted code prefixes, a status byte with the H flag clear, and re-alignment in the middle of a line.

// File: rtl/hsync_gen.sv
module hsync_gen #(
  parameter int OFS_W      = 11,
  parameter int LINE_525   = 1716,
  parameter int LINE_525SQ = 1560,
  parameter int LINE_625   = 1728,
  parameter int BEG_RST    = 2,
  parameter int END_RST    = 0,
  parameter int H_BIT      = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [7:0]       vid_byte,
  input  logic [1:0]       std_sel,
  input  logic             cfg_we,
  input  logic [OFS_W-1:0] cfg_beg,
  input  logic [OFS_W-1:0] cfg_end,
  input  logic             cfg_pol,
  output logic             hs_out
);

  typedef enum logic [1:0] {SEEK, GOT_FF, GOT_FF00, GOT_FF0000} mstate_t;

  mstate_t          m_q;
  logic [OFS_W-1:0] cnt_q, beg_q, end_q, line_total;
  logic             pol_q, hs_act;

  wire is_ff   = (vid_byte == 8'hFF);
  wire is_00   = (vid_byte == 8'h00);
  wire eav_hit = (m_q == GOT_FF0000) && vid_byte[H_BIT];
  wire at_last = (cnt_q >= line_total - OFS_W'(1));

  always_comb begin
    case (std_sel)
      2'd1:    line_total = OFS_W'(LINE_525SQ);
      2'd2:    line_total = OFS_W'(LINE_625);
      default: line_total = OFS_W'(LINE_525);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        m_q <= SEEK;
    else if (is_ff) m_q <= GOT_FF;
    else begin
      case (m_q)
        GOT_FF:   m_q <= is_00 ? GOT_FF00 : SEEK;
        GOT_FF00: m_q <= is_00 ? GOT_FF0000 : SEEK;
        default:  m_q <= SEEK;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst || eav_hit || at_last) cnt_q <= '0;
    else                           cnt_q <= cnt_q + OFS_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      beg_q <= OFS_W'(BEG_RST);
      end_q <= OFS_W'(END_RST);
      pol_q <= 1'b0;
    end else if (cfg_we) begin
      beg_q <= cfg_beg;
      end_q <= cfg_end;
      pol_q <= cfg_pol;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                 hs_act <= 1'b0;
    else if (cnt_q == beg_q) hs_act <= 1'b1;
    else if (cnt_q == end_q) hs_act <= 1'b0;
  end

  assign hs_out = hs_act ^ pol_q;

  AST_EAV_ZERO: assert property (@(posedge clk) disable iff (rst) eav_hit |=> cnt_q == '0); // R2
  AST_WRAP: assert property (@(posedge clk) disable iff (rst) (cnt_q >= line_total - OFS_W'(1)) |=> cnt_q == '0); // R4
  AST_STEP: assert property (@(posedge clk) disable iff (rst) (!eav_hit && cnt_q < line_total - OFS_W'(1)) |=> cnt_q == $past(cnt_q) + OFS_W'(1)); // R4
  AST_RISE: assert property (@(posedge clk) disable iff (rst) (cnt_q == beg_q) |=> hs_act); // R5
  AST_FALL: assert property (@(posedge clk) disable iff (rst) (cnt_q == end_q && cnt_q != beg_q) |=> !hs_act); // R5
  AST_HOLD: assert property (@(posedge clk) disable iff (rst) (cnt_q != beg_q && cnt_q != end_q) |=> $stable(hs_act)); // R5
  AST_CFG_LOAD: assert property (@(posedge clk) disable iff (rst) cfg_we |=> (beg_q == $past(cfg_beg) && end_q == $past(cfg_end) && pol_q == $past(cfg_pol))); // R8

endmodule

// File: tb/hsync_gen_bench.sv
module hsync_gen_bench;
  localparam int CLK_PERIOD = 10;
  localparam int W = 11;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [7:0]   vid_byte = 8'h10;
  logic [1:0]   std_sel = 2'd0;
  logic         cfg_we = 1'b0;
  logic [W-1:0] cfg_beg = '0;
  logic [W-1:0] cfg_end = '0;
  logic         cfg_pol = 1'b0;
  logic         hs_out;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hsync_gen u_hsync_gen (
    .clk(clk), .rst(rst), .vid_byte(vid_byte), .std_sel(std_sel),
    .cfg_we(cfg_we), .cfg_beg(cfg_beg), .cfg_end(cfg_end),
    .cfg_pol(cfg_pol), .hs_out(hs_out)
  );

  function automatic int line_len(input int s);
    case (s)
      1: return 1560;
      2: return 1728;
      default: return 1716;
    endcase
  endfunction

  function automatic bit exp_act(input int p, input int b, input int e);
    if (b == e) return 1'b1;
    if (b < e)  return (p >= b) && (p < e);
    return (p >= b) || (p < e);
  endfunction

  task automatic check(input bit exp, input string req);
    n_chk++;
    if (hs_out !== exp) begin
      n_bad++;
      $display("FAIL %s: hs_out=%0b expected %0b at %0t", req, hs_out, exp, $time);
    end
  endtask

  task automatic tick(input logic [7:0] b);
    @(negedge clk);
    vid_byte = b;
    cfg_we = 1'b0;
  endtask

  task automatic wr(input int b, input int e, input bit p);
    @(negedge clk);
    vid_byte = 8'h10;
    cfg_beg = W'(b); cfg_end = W'(e); cfg_pol = p; cfg_we = 1'b1;
  endtask

  task automatic send_eav();
    tick(8'hFF); tick(8'h00); tick(8'h00); tick(8'h9D);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick((i % 2) ? 8'h80 : 8'h10);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int bs [4];
    int es [4];
    repeat (3) @(negedge clk);
    check(1'b0, "R1 reset");
    rst = 1'b0;
    tick(8'h10); check(1'b0, "R1 edge1");
    tick(8'h10); check(1'b0, "R1 edge2");
    tick(8'h10); check(1'b1, "R1 edge3 default begin");

    for (int s = 0; s < 4; s++) begin
      int t;
      t = line_len(s);
      bs[0] = 2;      es[0] = 0;
      bs[1] = 22;     es[1] = 20;
      bs[2] = t - 18; es[2] = t - 20;
      bs[3] = 100;    es[3] = 228;
      @(negedge clk); std_sel = 2'(s);
      for (int c = 0; c < 4; c++) begin
        for (int p = 0; p < 2; p++) begin
          wr(bs[c], es[c], p[0]);
          send_eav();
          for (int i = 1; i <= 2*t + 1; i++) begin
            @(negedge clk);
            vid_byte = (i % 2) ? 8'h80 : 8'h10;
            if (i >= t + 2)
              check(exp_act((i - 2) % t, bs[c], es[c]) ^ p[0], "R4 R5 R6 R7 R8 sweep");
          end
        end
      end
    end

    @(negedge clk); std_sel = 2'd0;
    wr(5, 10, 1'b0);
    idle(300);
    send_eav();
    idle(7);  check(1'b1, "R9 realign rise");
    idle(4);  check(1'b1, "R9 realign high");
    idle(1);  check(1'b0, "R9 realign fall");

    idle(500);
    tick(8'hFF); tick(8'h00); tick(8'h10); tick(8'h00); tick(8'h00); tick(8'h9D);
    idle(7);  check(1'b0, "R3 broken prefix ignored");

    idle(500);
    tick(8'hFF); tick(8'h00); tick(8'h00); tick(8'h80);
    idle(7);  check(1'b0, "R3 status H=0 ignored");

    idle(500);
    tick(8'hFF); tick(8'h00); tick(8'hFF); tick(8'h00); tick(8'h00); tick(8'h9D);
    idle(6);  check(1'b0, "R2 R3 restart before begin");
    idle(1);  check(1'b1, "R2 R3 restart match rise");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule